// File: doc/BRIEF.md
# Tiled Pixel Job Scheduler

This block turns a view window on the complex plane into a stream of per-pixel iteration jobs for a fractal core array. After a start pulse it walks the frame one rectangular tile at a time. For each sample it emits the fixed-point coordinate of that sample, the framebuffer index of the pixel it belongs to, the iteration limit and the fractal mode. The two operands a core needs, the starting value z0 and the additive constant c, are set from the mode. Jobs may finish out of order further down the pipeline, because every job carries its own pixel index.

Coordinates are signed Q4.22 words (26 bits by default). They are built by running additions of the per-pixel step, so the block has no multiplier. A scale setting makes a quick coarse pass that samples only a subgrid of the frame. A later pass at a finer scale then fills in the rest. All configuration is read once, on the start pulse. Jobs leave on a valid/ready interface. When `job_valid` is high and `job_ready` is low, the job is held unchanged. A job is consumed only on a cycle where both are high. `done` is a plain one-cycle status pulse.

Top module: `tile_job_sched`

## Requirements
- R1: The frame (default 1280 by 720) is split into tiles of 32 by 16 pixels. Tiles are visited left to right along a tile row, and tile rows from top to bottom. Inside a tile, samples go left to right and then down.
- R2: `job_idx` equals y*FRAME_W + x for the pixel at column x and row y of the sample.
- R3: The sample coordinate is re = origin_re + x*step_re and im = origin_im + y*step_im, taken modulo 2^COORD_W (two's complement Q4.22).
- R4: In mode code 1 (Julia), z0 is the sample coordinate and c is the captured Julia constant.
- R5: In mode codes 0 (Mandelbrot), 2 (Burning Ship) and 3 (Tricorn), c is the sample coordinate and z0 is zero. `job_mode` carries the captured mode code with every job.
- R6: Scale code k in 0..3 sets the sample spacing s = 2^k. Only pixels whose x and y are both multiples of s are emitted, in the order of R1.
- R7: When `job_valid` is high and `job_ready` is low, every job output keeps its value in the next cycle. No job is skipped or repeated.
- R8: `done` is high for exactly one cycle: the cycle after the handshake of the last job of a pass. `job_valid` is low in that cycle.
- R9: The mode, scale, origin, steps, Julia constant and iteration limit are captured on an accepted start. A start while a pass is running is ignored. Configuration changes during a pass have no effect on it.
- R10: During and straight after reset, `job_valid` and `done` are low. The first job appears in the cycle after an accepted start.
- R11: `job_max_iter` carries the iteration limit captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass (taken only when idle) |
| cfg_origin_re | input | COORD_W | Real part at pixel (0,0) |
| cfg_origin_im | input | COORD_W | Imaginary part at pixel (0,0) |
| cfg_step_re | input | COORD_W | Real increment per column |
| cfg_step_im | input | COORD_W | Imaginary increment per row |
| cfg_julia_re | input | COORD_W | Julia constant, real part |
| cfg_julia_im | input | COORD_W | Julia constant, imaginary part |
| cfg_mode | input | 2 | 0 Mandelbrot, 1 Julia, 2 Burning Ship, 3 Tricorn |
| cfg_scale | input | 2 | Log2 of the sample spacing |
| cfg_max_iter | input | ITER_W | Iteration limit |
| job_valid | output | 1 | A job is offered |
| job_ready | input | 1 | The consumer accepts the job |
| job_z0_re | output | COORD_W | Starting z, real part |
| job_z0_im | output | COORD_W | Starting z, imaginary part |
| job_c_re | output | COORD_W | Constant c, real part |
| job_c_im | output | COORD_W | Constant c, imaginary part |
| job_idx | output | IDX_W | Framebuffer pixel index |
| job_max_iter | output | ITER_W | Iteration limit for this job |
| job_mode | output | 2 | Fractal mode for this job |
| done | output | 1 | One-cycle pulse after the final job |

## Verification
The assertions assume that the frame dimensions are whole multiples of the tile dimensions, and that each tile dimension is at least 8, so every scale code divides a tile evenly. They also assume `start` is sampled only as a level in the cycle it is high, and that `job_ready` may take any value in any cycle. The stimulus uses a reduced frame that is still several tiles wide and tall. It drives `job_ready` randomly at different densities and holds it high for a full pass. In one pass it raises `start` and changes every configuration input while jobs are still flowing, so the captured values are the only ones that reach the outputs.

// File: rtl/fsched_pkg.sv
package fsched_pkg;

  typedef enum logic [1:0] {
    FM_MANDEL  = 2'd0,
    FM_JULIA   = 2'd1,
    FM_SHIP    = 2'd2,
    FM_TRICORN = 2'd3
  } frac_mode_e;

  // Which boundary the walk crosses when the current sample is consumed.
  typedef enum logic [2:0] {
    WE_COL  = 3'd0,  // next sample in the same tile row
    WE_ROW  = 3'd1,  // next row inside the tile
    WE_TILE = 3'd2,  // next tile in the same tile row
    WE_TROW = 3'd3,  // first tile of the next tile row
    WE_END  = 3'd4   // last sample of the pass
  } walk_ev_e;

endpackage

// File: rtl/fsched_walk.sv
module fsched_walk
  import fsched_pkg::*;
#(
  parameter int TILE_W  = 32,
  parameter int TILE_H  = 16,
  parameter int TILES_X = 40,
  parameter int TILES_Y = 45
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       adv,
  input  logic [1:0] scale_lg,
  output walk_ev_e   ev
);

  localparam int PXW = $clog2(TILE_W) + 1;
  localparam int PYW = $clog2(TILE_H) + 1;
  localparam int TXW = $clog2(TILES_X) + 1;
  localparam int TYW = $clog2(TILES_Y) + 1;
  localparam logic [PXW-1:0] TW_V = PXW'(TILE_W);
  localparam logic [PYW-1:0] TH_V = PYW'(TILE_H);

  logic [PXW-1:0] px_q, px_lim;
  logic [PYW-1:0] py_q, py_lim;
  logic [TXW-1:0] tx_q;
  logic [TYW-1:0] ty_q;
  logic col_last, row_last, tx_last, ty_last;

  // Samples per tile row / column shrink with the spacing.
  assign px_lim = (TW_V >> scale_lg) - PXW'(1);
  assign py_lim = (TH_V >> scale_lg) - PYW'(1);

  assign col_last = (px_q == px_lim);
  assign row_last = (py_q == py_lim);
  assign tx_last  = (tx_q == TXW'(TILES_X - 1));
  assign ty_last  = (ty_q == TYW'(TILES_Y - 1));

  always_comb begin
    if (!col_last)      ev = WE_COL;
    else if (!row_last) ev = WE_ROW;
    else if (!tx_last)  ev = WE_TILE;
    else if (!ty_last)  ev = WE_TROW;
    else                ev = WE_END;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      px_q <= '0;
      py_q <= '0;
      tx_q <= '0;
      ty_q <= '0;
    end else if (adv) begin
      unique case (ev)
        WE_COL: px_q <= px_q + PXW'(1);
        WE_ROW: begin
          px_q <= '0;
          py_q <= py_q + PYW'(1);
        end
        WE_TILE: begin
          px_q <= '0;
          py_q <= '0;
          tx_q <= tx_q + TXW'(1);
        end
        WE_TROW: begin
          px_q <= '0;
          py_q <= '0;
          tx_q <= '0;
          ty_q <= ty_q + TYW'(1);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fsched_accum.sv
module fsched_accum
  import fsched_pkg::*;
#(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         load,
  input  logic         adv,
  input  walk_ev_e     ev,
  input  logic [W-1:0] init,
  input  logic [W-1:0] d_col,
  input  logic [W-1:0] d_row,
  input  logic [W-1:0] d_tile,
  input  logic [W-1:0] d_trow,
  output logic [W-1:0] cur
);

  // Four nested bases: tile row, tile, row within tile, current sample.
  logic [W-1:0] trow_q, tile_q, row_q, cur_q;
  logic [W-1:0] trow_nx, tile_nx, row_nx;

  assign trow_nx = trow_q + d_trow;
  assign tile_nx = tile_q + d_tile;
  assign row_nx  = row_q + d_row;

  always_ff @(posedge clk) begin
    if (load) begin
      trow_q <= init;
      tile_q <= init;
      row_q  <= init;
      cur_q  <= init;
    end else if (adv) begin
      unique case (ev)
        WE_COL: cur_q <= cur_q + d_col;
        WE_ROW: begin
          row_q <= row_nx;
          cur_q <= row_nx;
        end
        WE_TILE: begin
          tile_q <= tile_nx;
          row_q  <= tile_nx;
          cur_q  <= tile_nx;
        end
        WE_TROW: begin
          trow_q <= trow_nx;
          tile_q <= trow_nx;
          row_q  <= trow_nx;
          cur_q  <= trow_nx;
        end
        default: ;
      endcase
    end
  end

  assign cur = cur_q;

endmodule

// File: rtl/fsched_operand.sv
module fsched_operand
  import fsched_pkg::*;
#(
  parameter int CW = 26
) (
  input  frac_mode_e    mode,
  input  logic [CW-1:0] pix_re,
  input  logic [CW-1:0] pix_im,
  input  logic [CW-1:0] k_re,
  input  logic [CW-1:0] k_im,
  output logic [CW-1:0] z0_re,
  output logic [CW-1:0] z0_im,
  output logic [CW-1:0] c_re,
  output logic [CW-1:0] c_im
);

  always_comb begin
    if (mode == FM_JULIA) begin
      z0_re = pix_re;
      z0_im = pix_im;
      c_re  = k_re;
      c_im  = k_im;
    end else begin
      z0_re = '0;
      z0_im = '0;
      c_re  = pix_re;
      c_im  = pix_im;
    end
  end

endmodule

// File: rtl/tile_job_sched.sv
module tile_job_sched
  import fsched_pkg::*;
#(
  parameter int FRAME_W = 1280,
  parameter int FRAME_H = 720,
  parameter int TILE_W  = 32,
  parameter int TILE_H  = 16,
  parameter int COORD_W = 26,
  parameter int ITER_W  = 16,
  localparam int IDX_W  = $clog2(FRAME_W * FRAME_H)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COORD_W-1:0] cfg_origin_re,
  input  logic [COORD_W-1:0] cfg_origin_im,
  input  logic [COORD_W-1:0] cfg_step_re,
  input  logic [COORD_W-1:0] cfg_step_im,
  input  logic [COORD_W-1:0] cfg_julia_re,
  input  logic [COORD_W-1:0] cfg_julia_im,
  input  logic [1:0]         cfg_mode,
  input  logic [1:0]         cfg_scale,
  input  logic [ITER_W-1:0]  cfg_max_iter,
  output logic               job_valid,
  input  logic               job_ready,
  output logic [COORD_W-1:0] job_z0_re,
  output logic [COORD_W-1:0] job_z0_im,
  output logic [COORD_W-1:0] job_c_re,
  output logic [COORD_W-1:0] job_c_im,
  output logic [IDX_W-1:0]   job_idx,
  output logic [ITER_W-1:0]  job_max_iter,
  output logic [1:0]         job_mode,
  output logic               done
);

  localparam int TILES_X = FRAME_W / TILE_W;
  localparam int TILES_Y = FRAME_H / TILE_H;
  localparam int TW_LG   = $clog2(TILE_W);
  localparam int TH_LG   = $clog2(TILE_H);

  // Pass control
  logic       busy_q, done_q;
  logic       load, fire, fire_last;
  walk_ev_e   ev;

  // Captured configuration
  frac_mode_e          mode_q;
  logic [1:0]          lg_q;
  logic [COORD_W-1:0]  step_q [2];
  logic [COORD_W-1:0]  jul_q  [2];
  logic [ITER_W-1:0]   maxit_q;

  logic [COORD_W-1:0]  org [2];
  logic [COORD_W-1:0]  pix [2];
  logic [IDX_W-1:0]    idx_cur;

  assign load      = start && !busy_q;
  assign fire      = busy_q && job_ready;
  assign fire_last = fire && (ev == WE_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire_last;
      if (load)           busy_q <= 1'b1;
      else if (fire_last) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      mode_q    <= frac_mode_e'(cfg_mode);
      lg_q      <= cfg_scale;
      step_q[0] <= cfg_step_re;
      step_q[1] <= cfg_step_im;
      jul_q[0]  <= cfg_julia_re;
      jul_q[1]  <= cfg_julia_im;
      maxit_q   <= cfg_max_iter;
    end
  end

  fsched_walk #(
    .TILE_W (TILE_W),
    .TILE_H (TILE_H),
    .TILES_X(TILES_X),
    .TILES_Y(TILES_Y)
  ) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (fire),
    .scale_lg(lg_q),
    .ev      (ev)
  );

  assign org[0] = cfg_origin_re;
  assign org[1] = cfg_origin_im;

  // Axis 0 moves along columns, axis 1 along rows.
  for (genvar g = 0; g < 2; g++) begin : g_axis
    logic [COORD_W-1:0] d_col, d_row, d_tile, d_trow;
    if (g == 0) begin : g_re
      assign d_col  = step_q[g] << lg_q;
      assign d_row  = '0;
      assign d_tile = step_q[g] << TW_LG;
      assign d_trow = '0;
    end else begin : g_im
      assign d_col  = '0;
      assign d_row  = step_q[g] << lg_q;
      assign d_tile = '0;
      assign d_trow = step_q[g] << TH_LG;
    end
    fsched_accum #(.W(COORD_W)) u_acc (
      .clk   (clk),
      .load  (load),
      .adv   (fire),
      .ev    (ev),
      .init  (org[g]),
      .d_col (d_col),
      .d_row (d_row),
      .d_tile(d_tile),
      .d_trow(d_trow),
      .cur   (pix[g])
    );
  end

  logic [IDX_W-1:0] di_col, di_row;
  assign di_col = IDX_W'(1) << lg_q;
  assign di_row = IDX_W'(FRAME_W) << lg_q;

  fsched_accum #(.W(IDX_W)) u_idx (
    .clk   (clk),
    .load  (load),
    .adv   (fire),
    .ev    (ev),
    .init  ('0),
    .d_col (di_col),
    .d_row (di_row),
    .d_tile(IDX_W'(TILE_W)),
    .d_trow(IDX_W'(TILE_H * FRAME_W)),
    .cur   (idx_cur)
  );

  fsched_operand #(.CW(COORD_W)) u_opnd (
    .mode  (mode_q),
    .pix_re(pix[0]),
    .pix_im(pix[1]),
    .k_re  (jul_q[0]),
    .k_im  (jul_q[1]),
    .z0_re (job_z0_re),
    .z0_im (job_z0_im),
    .c_re  (job_c_re),
    .c_im  (job_c_im)
  );

  assign job_valid    = busy_q;
  assign job_idx      = idx_cur;
  assign job_max_iter = maxit_q;
  assign job_mode     = mode_q;
  assign done         = done_q;

endmodule

// File: rtl/fsched_chk.sv
module fsched_chk #(
  parameter int FRAME_W = 1280,
  parameter int FRAME_H = 720,
  parameter int COORD_W = 26,
  parameter int ITER_W  = 16,
  parameter int IDX_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [COORD_W-1:0] cfg_julia_re,
  input logic [COORD_W-1:0] cfg_julia_im,
  input logic [1:0]         cfg_scale,
  input logic [ITER_W-1:0]  cfg_max_iter,
  input logic               job_valid,
  input logic               job_ready,
  input logic [COORD_W-1:0] job_z0_re,
  input logic [COORD_W-1:0] job_z0_im,
  input logic [COORD_W-1:0] job_c_re,
  input logic [COORD_W-1:0] job_c_im,
  input logic [IDX_W-1:0]   job_idx,
  input logic [ITER_W-1:0]  job_max_iter,
  input logic [1:0]         job_mode,
  input logic               done
);

  localparam int NPIX = FRAME_W * FRAME_H;

  logic [1:0]          lg_k;
  logic [COORD_W-1:0]  jre_k, jim_k;
  logic [ITER_W-1:0]   mi_k;
  int                  smask;

  always_ff @(posedge clk) begin
    if (start && !job_valid) begin
      lg_k  <= cfg_scale;
      jre_k <= cfg_julia_re;
      jim_k <= cfg_julia_im;
      mi_k  <= cfg_max_iter;
    end
  end

  assign smask = (1 << lg_k) - 1;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> int'(job_idx) < NPIX);  // R2

  AST_IDX_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> (((int'(job_idx) % FRAME_W) & smask) == 0) &&
                  (((int'(job_idx) / FRAME_W) & smask) == 0));  // R6

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && !job_ready |=> job_valid && $stable(job_idx) &&
      $stable(job_z0_re) && $stable(job_z0_im) && $stable(job_c_re) &&
      $stable(job_c_im) && $stable(job_mode) && $stable(job_max_iter));  // R7

  AST_JULIA_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && job_mode == 2'd1 |-> job_c_re == jre_k && job_c_im == jim_k);  // R4

  AST_PLAIN_Z0: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && job_mode != 2'd1 |-> job_z0_re == '0 && job_z0_im == '0);  // R5

  AST_MAXIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> job_max_iter == mi_k);  // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !job_valid && $past(job_valid && job_ready));  // R8

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && $past(job_valid) |-> $stable(job_mode));  // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !job_valid && !done);  // R10

endmodule

bind tile_job_sched fsched_chk #(
  .FRAME_W(FRAME_W),
  .FRAME_H(FRAME_H),
  .COORD_W(COORD_W),
  .ITER_W (ITER_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .cfg_julia_re(cfg_julia_re),
  .cfg_julia_im(cfg_julia_im),
  .cfg_scale   (cfg_scale),
  .cfg_max_iter(cfg_max_iter),
  .job_valid   (job_valid),
  .job_ready   (job_ready),
  .job_z0_re   (job_z0_re),
  .job_z0_im   (job_z0_im),
  .job_c_re    (job_c_re),
  .job_c_im    (job_c_im),
  .job_idx     (job_idx),
  .job_max_iter(job_max_iter),
  .job_mode    (job_mode),
  .done        (done)
);

// File: tb/sim_tile_job_sched.sv
`timescale 1ns/1ps
module sim_tile_job_sched;

  localparam int FW = 128;
  localparam int FH = 48;
  localparam int TW = 32;
  localparam int TH = 16;
  localparam int CW = 26;
  localparam int IW = 16;
  localparam int XW = $clog2(FW * FH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] o_re = '0, o_im = '0, s_re = '0, s_im = '0, j_re = '0, j_im = '0;
  logic [1:0]    mode = '0, scale = '0;
  logic [IW-1:0] maxit = '0;
  logic          job_ready = 1'b0;
  logic          job_valid, done;
  logic [CW-1:0] z0_re, z0_im, c_re, c_im;
  logic [XW-1:0] job_idx;
  logic [IW-1:0] job_max_iter;
  logic [1:0]    job_mode;

  always #2 clk = ~clk;  // 250 MHz

  tile_job_sched #(
    .FRAME_W(FW), .FRAME_H(FH), .TILE_W(TW), .TILE_H(TH),
    .COORD_W(CW), .ITER_W(IW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_origin_re(o_re), .cfg_origin_im(o_im),
    .cfg_step_re(s_re), .cfg_step_im(s_im),
    .cfg_julia_re(j_re), .cfg_julia_im(j_im),
    .cfg_mode(mode), .cfg_scale(scale), .cfg_max_iter(maxit),
    .job_valid(job_valid), .job_ready(job_ready),
    .job_z0_re(z0_re), .job_z0_im(z0_im), .job_c_re(c_re), .job_c_im(c_im),
    .job_idx(job_idx), .job_max_iter(job_max_iter), .job_mode(job_mode),
    .done(done)
  );

  typedef struct {
    int            idx;
    logic [CW-1:0] re;
    logic [CW-1:0] im;
  } job_t;

  job_t          q[$];
  bit            m_busy = 0, m_done = 0;
  logic [1:0]    m_mode;
  logic [IW-1:0] m_maxit;
  logic [CW-1:0] m_jre, m_jim;
  int            n_tests = 0, n_fail = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: list every sample of the pass in walk order.
  task automatic build_pass();
    int s;
    s = 1 << scale;
    q.delete();
    for (int ty = 0; ty < FH / TH; ty++)
      for (int tx = 0; tx < FW / TW; tx++)
        for (int py = 0; py < TH; py += s)
          for (int px = 0; px < TW; px += s) begin
            job_t j;
            int x, y;
            x = tx * TW + px;
            y = ty * TH + py;
            j.idx = y * FW + x;
            j.re  = CW'(longint'(o_re) + longint'(x) * longint'(s_re));
            j.im  = CW'(longint'(o_im) + longint'(y) * longint'(s_im));
            q.push_back(j);
          end
    m_mode  = mode;
    m_maxit = maxit;
    m_jre   = j_re;
    m_jim   = j_im;
  endtask

  // Called just after a falling edge: compare, then advance the model
  // by the rising edge that follows, using the inputs now applied.
  task automatic tick();
    bit was_busy;
    chk(job_valid == m_busy, "R8 R10", "job_valid", job_valid, m_busy);
    chk(done == m_done, "R8", "done", done, m_done);
    if (m_busy && job_valid) begin
      job_t e;
      logic [CW-1:0] ez0r, ez0i, ecr, eci;
      e = q[0];
      if (m_mode == 2'd1) begin
        ez0r = e.re; ez0i = e.im; ecr = m_jre; eci = m_jim;
      end else begin
        ez0r = '0; ez0i = '0; ecr = e.re; eci = e.im;
      end
      chk(int'(job_idx) == e.idx, "R1 R2 R6 R7", "job_idx", job_idx, e.idx);
      chk(z0_re == ez0r && z0_im == ez0i, (m_mode == 2'd1) ? "R3 R4" : "R5",
          "z0", {z0_re, z0_im}, {ez0r, ez0i});
      chk(c_re == ecr && c_im == eci, (m_mode == 2'd1) ? "R4 R9" : "R3 R5",
          "c", {c_re, c_im}, {ecr, eci});
      chk(job_mode == m_mode, "R5 R9", "job_mode", job_mode, m_mode);
      chk(job_max_iter == m_maxit, "R11", "job_max_iter", job_max_iter, m_maxit);
    end
    was_busy = m_busy;
    m_done = 0;
    if (m_busy && job_ready) begin
      void'(q.pop_front());
      if (q.size() == 0) begin
        m_busy = 0;
        m_done = 1;
      end
    end
    if (start && !was_busy) begin
      build_pass();
      m_busy = 1;
    end
    @(negedge clk);
  endtask

  task automatic run_pass(logic [1:0] md, logic [1:0] sc,
                          logic [CW-1:0] ore, logic [CW-1:0] oim,
                          logic [CW-1:0] sre, logic [CW-1:0] sim,
                          logic [IW-1:0] mi, int ready_pct, bit poke);
    mode = md; scale = sc; o_re = ore; o_im = oim; s_re = sre; s_im = sim;
    j_re = 26'h0a5_5a5; j_im = 26'h3f0_0f1; maxit = mi;
    start = 1'b1;
    job_ready = 1'b0;
    tick();
    start = 1'b0;
    do begin
      job_ready = ($urandom_range(0, 99) < ready_pct);
      if (poke) begin
        // R9: restart requests and config churn while the pass runs
        start = ($urandom_range(0, 9) == 0) && m_busy;
        mode  = 2'($urandom);  scale = 2'($urandom);
        o_re  = CW'($urandom); s_re  = CW'($urandom);
        o_im  = CW'($urandom); s_im  = CW'($urandom);
        j_re  = CW'($urandom); j_im  = CW'($urandom);
        maxit = IW'($urandom);
      end
      tick();
      start = 1'b0;
    end while (m_busy || m_done);
    job_ready = 1'b1;
    repeat (3) tick();  // idle: nothing offered, no stray done
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual %0d cycles expected completion", 150000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(job_valid == 1'b0, "R10", "job_valid in reset", job_valid, 0);
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (2) tick();
    // Mandelbrot, full density, no back-pressure
    run_pass(2'd0, 2'd0, 26'h380_0000, 26'h3c0_0000, 26'h000_1000, 26'h000_0c00,
             16'd256, 100, 1'b0);
    // Julia, spacing 2, heavy back-pressure
    run_pass(2'd1, 2'd1, 26'h3e0_0000, 26'h020_0000, 26'h000_2345, 26'h3ff_f123,
             16'd1000, 40, 1'b0);
    // Burning Ship, spacing 4, negative steps wrap the coordinate
    run_pass(2'd2, 2'd2, 26'h1ff_fff0, 26'h200_0010, 26'h3ff_0000, 26'h3fe_8000,
             16'd64, 70, 1'b0);
    // Tricorn, spacing 8, restart attempts and config churn mid-pass
    run_pass(2'd3, 2'd3, 26'h012_3456, 26'h3ab_cdef, 26'h004_0000, 26'h002_0000,
             16'hffff, 50, 1'b1);
    // Julia, full density, churn while stalled often
    run_pass(2'd1, 2'd0, 26'h000_0000, 26'h000_0000, 26'h000_0400, 26'h000_0400,
             16'd1, 60, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule